// File: doc/BRIEF.md
# Virtual Segment Decoder with Fault Capture

This block sits between an address-generation stage and a TLB lookup unit. Each request carries a 32-bit virtual address, a store flag, a user-mode flag and an error-level flag. The top three address bits choose the route. Some addresses are refused outright. Two kernel windows are translated by subtracting a fixed base. With the error-level flag set, the lower half of the space maps one-to-one. Everything else goes to the TLB lookup unit over a request/acknowledge handshake, with at most one lookup outstanding at a time.

Every request ends in a one-cycle response. The response carries a physical address and read/write permission bits, or a fault flag with an exception code and a refill flag. When a response faults, three fault registers are loaded from the faulting address in the same cycle the response appears: the bad-address register, the context register and the entry-high register. The parts of these registers that are not loaded keep their value.

The control is a three-state machine:
- **IDLE** accepts a request. A request that needs the lookup unit moves to **WAIT** (transition *issue*). Any other request moves straight to **RESP** (transition *resolve*).
- **WAIT** holds the lookup request until the acknowledge arrives, then moves to **RESP** (transition *return*).
- **RESP** shows the result for one cycle and goes back to **IDLE** (transition *retire*).

Top module: `vseg_xlate`

## Requirements
- R1: In user mode, an address with bit 31 set faults with no lookup request. The exception code is 5 for a store and 4 for a load, the refill flag is 0, and the response comes one cycle after acceptance.
- R2: When the error-level flag is set and address bit 31 is clear, the physical address equals the virtual address and the permission is 2'b11 (bit 0 read, bit 1 write). No lookup request is made. User mode does not change this.
- R3: An address from 0x80000000 to 0x9FFFFFFF translates to the address minus 0x80000000, with permission 2'b11 and no lookup request.
- R4: An address from 0xA0000000 to 0xBFFFFFFF translates to the address minus 0xA0000000, with permission 2'b11 and no lookup request.
- R5: Addresses below 0x80000000 with the error-level flag clear, and kernel addresses at or above 0xC0000000, raise `tlb_req` with `tlb_vaddr` equal to the address. `tlb_req` and `tlb_vaddr` hold until `tlb_ack`, and `req_ready` stays low meanwhile.
- R6: A lookup hit with a valid entry returns the lookup unit's physical address. The permission has bit 0 set and bit 1 equal to the dirty flag. A store to a clean entry instead faults with code 1 (modify).
- R7: A lookup miss faults with code 3 for a store and code 2 for a load, and sets the refill flag.
- R8: A hit on an invalid entry faults with code 3 for a store and code 2 for a load, with the refill flag clear.
- R9: On a fault, `bad_vaddr` takes the full faulting address.
- R10: On a fault, `ctx_reg` keeps bits 31:23, takes bits 22:4 from the address shifted right by 9, and clears bits 3:0.
- R11: On a fault, `ehi_reg` keeps bits 7:0, takes bits 31:13 from the address, and clears bits 12:8.
- R12: A response without a fault leaves all three fault registers unchanged and reports code 0. `rsp_valid` is high for exactly one cycle per request.
- R13: After reset, `req_ready` is 1. `rsp_valid` and `tlb_req` are 0. `bad_vaddr` is 0, `ctx_reg` equals CTX_RST and `ehi_reg` equals EHI_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | Request issued in user mode |
| req_erl | input | 1 | Error-level flag |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_perm | output | 2 | Bit 0 read, bit 1 write |
| rsp_fault | output | 1 | Response is a fault |
| rsp_exc | output | 3 | 0 none, 1 modify, 2 TLB load, 3 TLB store, 4 load address error, 5 store address error |
| rsp_refill | output | 1 | Fault came from a lookup miss |
| tlb_req | output | 1 | Lookup request |
| tlb_vaddr | output | 32 | Address for lookup |
| tlb_write | output | 1 | Lookup is for a store |
| tlb_ack | input | 1 | Lookup result present |
| tlb_hit | input | 1 | An entry matched |
| tlb_valid | input | 1 | Matched entry is valid |
| tlb_dirty | input | 1 | Matched entry is writable |
| tlb_paddr | input | 32 | Translated physical address |
| bad_vaddr | output | 32 | Bad-address register |
| ctx_reg | output | 32 | Context register |
| ehi_reg | output | 32 | Entry-high register |

## Verification
If the state register lands in the wrong state, the ports show it within one cycle. `tlb_req` rises for a direct-mapped address, `rsp_valid` stays high for two cycles, or `req_ready` drops and never returns. A wrong captured result shows up in the same cycle as `rsp_valid`: a bad code, a missing refill flag, or a fault register that moved on a clean response. The context and entry-high bits that should be kept are compared after every fault, so a bad merge mask is caught at the first faulting request.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    localparam int VA_W = 32;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_MOD  = 3'd1,
        EXC_TLBL = 3'd2,
        EXC_TLBS = 3'd3,
        EXC_ADEL = 3'd4,
        EXC_ADES = 3'd5
    } exc_e;

    typedef enum logic [1:0] {
        ROUTE_FAULT  = 2'd0,
        ROUTE_DIRECT = 2'd1,
        ROUTE_LOOKUP = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic [1:0]      perm;
        logic            fault;
        exc_e            exc;
        logic            refill;
    } xres_t;

endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
    import vseg_pkg::*;
#(
    parameter logic [VA_W-1:0] LOW_WIN_BASE  = 32'h8000_0000,
    parameter logic [VA_W-1:0] HIGH_WIN_BASE = 32'hA000_0000
) (
    input  logic [VA_W-1:0] addr,
    input  logic            write,
    input  logic            user,
    input  logic            erl,
    output route_e          route,
    output xres_t           direct
);

    localparam int SEG_MSB = VA_W - 1;
    localparam int SEG_LSB = VA_W - 3;

    logic [2:0] seg;
    assign seg = addr[SEG_MSB:SEG_LSB];

    always_comb begin
        route         = ROUTE_LOOKUP;
        direct.paddr  = '0;
        direct.perm   = 2'b00;
        direct.fault  = 1'b0;
        direct.exc    = EXC_NONE;
        direct.refill = 1'b0;
        if (user && addr[SEG_MSB]) begin
            route        = ROUTE_FAULT;
            direct.fault = 1'b1;
            direct.exc   = write ? EXC_ADES : EXC_ADEL;
        end else begin
            unique casez (seg)
                3'b0??: begin
                    if (erl) begin
                        route        = ROUTE_DIRECT;
                        direct.paddr = addr;
                        direct.perm  = 2'b11;
                    end
                end
                3'b100: begin
                    route        = ROUTE_DIRECT;
                    direct.paddr = addr - LOW_WIN_BASE;
                    direct.perm  = 2'b11;
                end
                3'b101: begin
                    route        = ROUTE_DIRECT;
                    direct.paddr = addr - HIGH_WIN_BASE;
                    direct.perm  = 2'b11;
                end
                default: route = ROUTE_LOOKUP;
            endcase
        end
    end

endmodule

// File: rtl/vseg_resolve.sv
module vseg_resolve
    import vseg_pkg::*;
(
    input  logic            write,
    input  logic            hit,
    input  logic            valid,
    input  logic            dirty,
    input  logic [VA_W-1:0] paddr,
    output xres_t           res
);

    always_comb begin
        res.paddr  = '0;
        res.perm   = 2'b00;
        res.fault  = 1'b1;
        res.exc    = write ? EXC_TLBS : EXC_TLBL;
        res.refill = 1'b0;
        if (!hit) begin
            res.refill = 1'b1;
        end else if (!valid) begin
            res.refill = 1'b0;
        end else if (write && !dirty) begin
            res.exc = EXC_MOD;
        end else begin
            res.fault = 1'b0;
            res.exc   = EXC_NONE;
            res.paddr = paddr;
            res.perm  = {dirty, 1'b1};
        end
    end

endmodule

// File: rtl/vseg_fault_regs.sv
module vseg_fault_regs
    import vseg_pkg::*;
#(
    parameter int              PAGE_BITS = 12,
    parameter int              ASID_W    = 8,
    parameter int              CTX_SPLIT = 23,
    parameter int              CTX_LOW   = 4,
    parameter logic [VA_W-1:0] CTX_RST   = 32'h5A80_0000,
    parameter logic [VA_W-1:0] EHI_RST   = 32'h0000_0037
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [VA_W-1:0] addr,
    output logic [VA_W-1:0] bad_vaddr,
    output logic [VA_W-1:0] ctx_reg,
    output logic [VA_W-1:0] ehi_reg
);

    localparam int              PAIR_LSB  = PAGE_BITS + 1;
    localparam int              CTX_SHIFT = PAIR_LSB - CTX_LOW;
    localparam logic [VA_W-1:0] ONE       = {{(VA_W-1){1'b0}}, 1'b1};
    localparam logic [VA_W-1:0] CTX_KEEP  = ~((ONE << CTX_SPLIT) - ONE);
    localparam logic [VA_W-1:0] CTX_LOAD  = ((ONE << CTX_SPLIT) - ONE) & ~((ONE << CTX_LOW) - ONE);
    localparam logic [VA_W-1:0] ASID_KEEP = (ONE << ASID_W) - ONE;
    localparam logic [VA_W-1:0] PAIR_MASK = ~((ONE << PAIR_LSB) - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_vaddr <= '0;
            ctx_reg   <= CTX_RST;
            ehi_reg   <= EHI_RST;
        end else if (load) begin
            bad_vaddr <= addr;
            ctx_reg   <= (ctx_reg & CTX_KEEP) | ((addr >> CTX_SHIFT) & CTX_LOAD);
            ehi_reg   <= (ehi_reg & ASID_KEEP) | (addr & PAIR_MASK);
        end
    end

endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
    import vseg_pkg::*;
#(
    parameter int              PAGE_BITS = 12,
    parameter int              ASID_W    = 8,
    parameter int              CTX_SPLIT = 23,
    parameter int              CTX_LOW   = 4,
    parameter logic [VA_W-1:0] CTX_RST   = 32'h5A80_0000,
    parameter logic [VA_W-1:0] EHI_RST   = 32'h0000_0037
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_addr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic            req_erl,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_perm,
    output logic            rsp_fault,
    output logic [2:0]      rsp_exc,
    output logic            rsp_refill,
    output logic            tlb_req,
    output logic [VA_W-1:0] tlb_vaddr,
    output logic            tlb_write,
    input  logic            tlb_ack,
    input  logic            tlb_hit,
    input  logic            tlb_valid,
    input  logic            tlb_dirty,
    input  logic [VA_W-1:0] tlb_paddr,
    output logic [VA_W-1:0] bad_vaddr,
    output logic [VA_W-1:0] ctx_reg,
    output logic [VA_W-1:0] ehi_reg
);

    state_e          state_q, state_d;
    logic [VA_W-1:0] addr_q;
    logic            write_q;
    xres_t           res_q, cap_res;
    logic            cap_en;
    logic [VA_W-1:0] cap_addr;
    route_e          route;
    xres_t           direct_res, lookup_res;

    vseg_decode u_decode (
        .addr   (req_addr),
        .write  (req_write),
        .user   (req_user),
        .erl    (req_erl),
        .route  (route),
        .direct (direct_res)
    );

    vseg_resolve u_resolve (
        .write (write_q),
        .hit   (tlb_hit),
        .valid (tlb_valid),
        .dirty (tlb_dirty),
        .paddr (tlb_paddr),
        .res   (lookup_res)
    );

    vseg_fault_regs #(
        .PAGE_BITS (PAGE_BITS),
        .ASID_W    (ASID_W),
        .CTX_SPLIT (CTX_SPLIT),
        .CTX_LOW   (CTX_LOW),
        .CTX_RST   (CTX_RST),
        .EHI_RST   (EHI_RST)
    ) u_fregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_en && cap_res.fault),
        .addr      (cap_addr),
        .bad_vaddr (bad_vaddr),
        .ctx_reg   (ctx_reg),
        .ehi_reg   (ehi_reg)
    );

    // next-state and capture control
    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (route == ROUTE_LOOKUP) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_RESP;
                        cap_en  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tlb_ack) begin
                    state_d = ST_RESP;
                    cap_en  = 1'b1;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign cap_res  = (state_q == ST_WAIT) ? lookup_res : direct_res;
    assign cap_addr = (state_q == ST_WAIT) ? addr_q : req_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            res_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                write_q <= req_write;
            end
            if (cap_en) begin
                res_q <= cap_res;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        tlb_req    = (state_q == ST_WAIT);
        rsp_valid  = (state_q == ST_RESP);
        tlb_vaddr  = addr_q;
        tlb_write  = write_q;
        rsp_paddr  = res_q.paddr;
        rsp_perm   = res_q.perm;
        rsp_fault  = res_q.fault;
        rsp_exc    = res_q.exc;
        rsp_refill = res_q.refill;
    end

endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk #(
    parameter int ASID_W    = 8,
    parameter int CTX_SPLIT = 23
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_user,
    input logic        rsp_valid,
    input logic [1:0]  rsp_perm,
    input logic        rsp_fault,
    input logic [2:0]  rsp_exc,
    input logic        rsp_refill,
    input logic        tlb_req,
    input logic [31:0] tlb_vaddr,
    input logic        tlb_ack,
    input logic [31:0] bad_vaddr,
    input logic [31:0] ctx_reg,
    input logic [31:0] ehi_reg
);

    a_r1_user_high_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_user && req_addr[31]) |=> (rsp_valid && rsp_fault));

    a_r5_lookup_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && !tlb_ack) |=> (tlb_req && $stable(tlb_vaddr)));

    a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |-> !req_ready);

    a_r6_clean_has_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_perm[0] && rsp_exc == 3'd0));

    a_r7_refill_is_tlb_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_refill) |-> (rsp_fault && (rsp_exc == 3'd2 || rsp_exc == 3'd3)));

    a_r9_badaddr_moves_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bad_vaddr) |-> (rsp_valid && rsp_fault));

    a_r10_ctx_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ctx_reg[31:CTX_SPLIT]));

    a_r11_asid_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ehi_reg[ASID_W-1:0]));

    a_r12_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind vseg_xlate vseg_xlate_chk #(
    .ASID_W    (ASID_W),
    .CTX_SPLIT (CTX_SPLIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_user   (req_user),
    .rsp_valid  (rsp_valid),
    .rsp_perm   (rsp_perm),
    .rsp_fault  (rsp_fault),
    .rsp_exc    (rsp_exc),
    .rsp_refill (rsp_refill),
    .tlb_req    (tlb_req),
    .tlb_vaddr  (tlb_vaddr),
    .tlb_ack    (tlb_ack),
    .bad_vaddr  (bad_vaddr),
    .ctx_reg    (ctx_reg),
    .ehi_reg    (ehi_reg)
);

// File: tb/vseg_xlate_bench.sv
`timescale 1ns/1ps
module vseg_xlate_bench;

    localparam logic [31:0] CTX_RST = 32'h5A80_0000;
    localparam logic [31:0] EHI_RST = 32'h0000_0037;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_erl = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;
    logic [2:0]  rsp_exc;
    logic        rsp_refill;
    logic        tlb_req;
    logic [31:0] tlb_vaddr;
    logic        tlb_write;
    logic        tlb_ack = 1'b0, tlb_hit = 1'b0, tlb_valid = 1'b0, tlb_dirty = 1'b0;
    logic [31:0] tlb_paddr = '0;
    logic [31:0] bad_vaddr, ctx_reg, ehi_reg;

    always #2.5 clk = ~clk;

    vseg_xlate #(.CTX_RST(CTX_RST), .EHI_RST(EHI_RST)) u_vseg_xlate (.*);

    typedef struct {
        string       tag;
        logic [31:0] pa;
        logic [1:0]  perm;
        logic        fault;
        logic [2:0]  exc;
        logic        refill;
        logic [31:0] badv, ctx, ehi;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0;
    logic [31:0] m_badv = 32'h0, m_ctx = CTX_RST, m_ehi = EHI_RST;

    logic        s_lookup = 1'b0, s_hit, s_valid, s_dirty;
    logic [31:0] s_pa, s_addr;
    int          s_dly = 0;

    task automatic chk(input string req, input logic ok, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] a, input logic w, u, e,
                       input logic hit, valid, dirty, input logic [31:0] tpa, input int dly);
        exp_t x;
        logic lk;
        x.tag = tag; x.pa = 0; x.perm = 0; x.fault = 0; x.exc = 0; x.refill = 0;
        lk = 1'b0;
        if (u && a[31]) begin
            x.fault = 1; x.exc = w ? 3'd5 : 3'd4;
        end else if (!a[31] && e) begin
            x.pa = a; x.perm = 2'b11;
        end else if (a >= 32'h8000_0000 && a < 32'hA000_0000) begin
            x.pa = a - 32'h8000_0000; x.perm = 2'b11;
        end else if (a >= 32'hA000_0000 && a < 32'hC000_0000) begin
            x.pa = a - 32'hA000_0000; x.perm = 2'b11;
        end else begin
            lk = 1'b1;
            if (!hit) begin
                x.fault = 1; x.exc = w ? 3'd3 : 3'd2; x.refill = 1;
            end else if (!valid) begin
                x.fault = 1; x.exc = w ? 3'd3 : 3'd2;
            end else if (w && !dirty) begin
                x.fault = 1; x.exc = 3'd1;
            end else begin
                x.pa = tpa; x.perm = {dirty, 1'b1};
            end
        end
        if (x.fault) begin
            m_badv = a;
            m_ctx  = (m_ctx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
            m_ehi  = (m_ehi & 32'h0000_00FF) | (a & 32'hFFFF_E000);
        end
        x.badv = m_badv; x.ctx = m_ctx; x.ehi = m_ehi;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        s_lookup = lk; s_hit = hit; s_valid = valid; s_dirty = dirty;
        s_pa = tpa; s_addr = a; s_dly = dly;
        q.push_back(x);
        req_addr = a; req_write = w; req_user = u; req_erl = e; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // TLB lookup responder
    initial begin
        forever begin
            @(negedge clk);
            if (tlb_ack) begin
                tlb_ack = 1'b0;
            end else if (tlb_req) begin
                if (s_dly == 0) begin
                    chk("R5", s_lookup && tlb_vaddr == s_addr && !req_ready,
                        $sformatf("lookup vaddr=%h ready=%b expected vaddr=%h ready=0 wanted=%b",
                                  tlb_vaddr, req_ready, s_addr, s_lookup));
                    tlb_hit = s_hit; tlb_valid = s_valid; tlb_dirty = s_dirty;
                    tlb_paddr = s_pa; tlb_ack = 1'b1;
                end else begin
                    if (!s_lookup) chk("R2", 1'b0, "lookup raised for a direct-mapped request, expected none");
                    s_dly--;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    chk("R12", 1'b0, "response with no request pending, expected none");
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    chk(x.tag, rsp_paddr == x.pa && rsp_perm == x.perm && rsp_fault == x.fault &&
                               rsp_exc == x.exc && rsp_refill == x.refill,
                        $sformatf("pa=%h perm=%b f=%b exc=%0d rf=%b expected pa=%h perm=%b f=%b exc=%0d rf=%b",
                                  rsp_paddr, rsp_perm, rsp_fault, rsp_exc, rsp_refill,
                                  x.pa, x.perm, x.fault, x.exc, x.refill));
                    chk(x.fault ? "R9/R10/R11" : "R12",
                        bad_vaddr == x.badv && ctx_reg == x.ctx && ehi_reg == x.ehi,
                        $sformatf("badv=%h ctx=%h ehi=%h expected badv=%h ctx=%h ehi=%h",
                                  bad_vaddr, ctx_reg, ehi_reg, x.badv, x.ctx, x.ehi));
                end
            end
        end
    end

    logic done = 1'b0;
    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", req_ready == 1'b1 && rsp_valid == 1'b0 && tlb_req == 1'b0 &&
                   bad_vaddr == 32'h0 && ctx_reg == CTX_RST && ehi_reg == EHI_RST,
            $sformatf("in reset ready=%b rv=%b tr=%b badv=%h ctx=%h ehi=%h expected 1 0 0 0 %h %h",
                      req_ready, rsp_valid, tlb_req, bad_vaddr, ctx_reg, ehi_reg, CTX_RST, EHI_RST));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", req_ready == 1'b1 && rsp_valid == 1'b0 && ctx_reg == CTX_RST && ehi_reg == EHI_RST,
            $sformatf("after reset ready=%b rv=%b ctx=%h ehi=%h", req_ready, rsp_valid, ctx_reg, ehi_reg));

        run("R1", 32'h8000_0000, 0, 1, 0, 0, 0, 0, 0, 0);
        run("R1", 32'hC123_4567, 1, 1, 0, 0, 0, 0, 0, 0);
        run("R1", 32'hFFFF_FFFF, 0, 1, 1, 0, 0, 0, 0, 0);
        run("R2", 32'h0040_0010, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R2", 32'h7FFF_FFFF, 0, 0, 1, 0, 0, 0, 0, 0);
        run("R3", 32'h8000_1234, 1, 0, 0, 0, 0, 0, 0, 0);
        run("R3", 32'h9FFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0);
        run("R4", 32'hA000_0000, 0, 0, 0, 0, 0, 0, 0, 0);
        run("R4", 32'hBFC0_0000, 1, 0, 0, 0, 0, 0, 0, 0);
        run("R6", 32'h0040_2004, 0, 0, 0, 1, 1, 1, 32'h0123_4004, 2);
        run("R6", 32'h7FFF_F000, 0, 1, 0, 1, 1, 0, 32'h0055_5000, 0);
        run("R6", 32'hC000_0000, 1, 0, 0, 1, 1, 1, 32'h0ABC_D000, 3);
        run("R6", 32'h1234_5678, 1, 0, 0, 1, 1, 0, 32'h0000_0000, 1);
        run("R7", 32'hC012_3456, 1, 0, 0, 0, 0, 0, 0, 0);
        run("R7", 32'h0000_2ABC, 0, 1, 0, 0, 1, 1, 0, 4);
        run("R8", 32'hDFFF_FFFF, 0, 0, 0, 1, 0, 1, 0, 1);
        run("R8", 32'hE765_4321, 1, 0, 0, 1, 0, 0, 0, 0);
        run("R12", 32'h8765_4320, 0, 0, 0, 0, 0, 0, 0, 0);
        run("R5", 32'hF000_0008, 0, 0, 0, 1, 1, 1, 32'h1FFF_0008, 6);

        repeat (20) @(negedge clk);
        chk("R12", q.size() == 0, $sformatf("pending=%0d expected 0", q.size()));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule